// File: doc/BRIEF.md
# Asynchronous Static-Memory Bus Master

This block lets on-chip logic run single read and write accesses on an external asynchronous static-memory bus. The bus has separate address and data pins. The block accepts one command at a time on a valid/ready port. Each command carries a direction flag, an address and write data. The block then drives an active-low chip select, an active-low output enable and an active-low write enable. It holds the address steady for the whole access and drives or samples a 16-bit data bus. The data bus is split into output, output-enable and input pins, and the three-state pad is placed outside the block.

Each access has three phases: address setup, data, and address hold. Their lengths come from three timing inputs, counted in clock cycles. The block samples these inputs when it accepts a command, so different slaves or different parts of a board can use different timing from one access to the next. During a write, the write strobe is one cycle shorter than the data phase, and the data stays valid after the strobe rises. The block needs no clock from the slave. Slow strobes are a matter of setting larger phase values.

Top module: `amem_bus_master`

## Requirements
- R1: After reset, and whenever `cmd_ready_o` is high, chip select, output enable and write enable are all high, `mem_dq_oe_o` is low, and `rsp_valid_o` is low out of reset.
- R2: An accepted command drives chip select low for exactly A+D consecutive cycles. A is the effective address-setup value and D is the effective data-setup value. The first A of these cycles have both strobes high. `mem_addr_o` equals the command address from the first chip-select cycle through the last hold cycle.
- R3: A read holds output enable low for exactly D consecutive cycles, namely the last D cycles of chip select. Write enable stays high throughout the read.
- R4: Read data is the value on `mem_dq_i` during the last output-enable-low cycle. It is returned on `rsp_rdata_o` with a single-cycle `rsp_valid_o` pulse.
- R5: A write holds write enable low for max(D-1,1) cycles, starting in the first data-phase cycle. `mem_dq_o` carries the command data and `mem_dq_oe_o` is high for exactly the D data cycles plus the H hold cycles.
- R6: After chip select rises, the block stays busy (`cmd_ready_o` low) for exactly H hold cycles, where H is the effective address-hold value. `rsp_valid_o` is asserted in the following cycle.
- R7: A timing input of 0 acts as 1 cycle. All three timing inputs are 8-bit values.
- R8: `cmd_ready_o` is low from the cycle after acceptance until the access completes. A `cmd_valid_i` presented while busy starts no access.
- R9: The timing inputs are sampled only in the accepting cycle. Changing them during an access does not alter that access.
- R10: Output enable and write enable are never low together. `mem_dq_oe_o` is never high during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block idle, command accepted when valid |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | AW (20) | Access address |
| cmd_wdata_i | input | DW (16) | Write data |
| tim_addr_setup_i | input | TW (8) | Address-setup cycles |
| tim_data_setup_i | input | TW (8) | Data-phase cycles |
| tim_addr_hold_i | input | TW (8) | Address-hold cycles |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DW (16) | Read data |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_addr_o | output | AW (20) | Address bus |
| mem_dq_o | output | DW (16) | Data bus out |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | DW (16) | Data bus in |

## Verification
The memory model presents a different value on the data bus in each output-enable cycle. A design that samples a cycle early or late therefore returns the wrong word instead of a plausible one. The bench sets the data phase to one cycle and all timing inputs to zero, so a design that does not clamp zero settings, or that computes the write strobe as D-1 without a floor, shows up as a missing strobe or a miscounted phase. The bench presents a stray command and changes the timing inputs while an access is running. A design that accepts the stray command produces an unmatched completion, and one that reads the timing inputs late produces phase lengths that do not match.

// File: rtl/amem_pkg.sv
package amem_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;
endpackage

// File: rtl/amem_timing_cfg.sv
module amem_timing_cfg #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] addr_setup_i,
  input  logic [TW-1:0] data_setup_i,
  input  logic [TW-1:0] addr_hold_i,
  output logic [TW-1:0] addr_setup_now_o,
  output logic [TW-1:0] data_setup_o,
  output logic [TW-1:0] addr_hold_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] ds_c, ah_c;

  // zero settings behave as one cycle
  assign addr_setup_now_o = (addr_setup_i == '0) ? ONE : addr_setup_i;
  assign ds_c             = (data_setup_i == '0) ? ONE : data_setup_i;
  assign ah_c             = (addr_hold_i  == '0) ? ONE : addr_hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_setup_o <= ONE;
      addr_hold_o  <= ONE;
    end else if (load_i) begin
      data_setup_o <= ds_c;
      addr_hold_o  <= ah_c;
    end
  end
endmodule

// File: rtl/amem_phase_seq.sv
module amem_phase_seq
  import amem_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] addr_setup_i,
  input  logic [TW-1:0] data_setup_i,
  input  logic [TW-1:0] addr_hold_i,
  output phase_e        phase_o,
  output logic [TW-1:0] cnt_o,
  output logic          done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_IDLE;
      cnt_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase_o)
        PH_IDLE: if (start_i) begin
          phase_o <= PH_ADDR;
          cnt_o   <= addr_setup_i - 1'b1;
        end
        PH_ADDR: if (cnt_o == '0) begin
          phase_o <= PH_DATA;
          cnt_o   <= data_setup_i - 1'b1;
        end else cnt_o <= cnt_o - 1'b1;
        PH_DATA: if (cnt_o == '0) begin
          phase_o <= PH_HOLD;
          cnt_o   <= addr_hold_i - 1'b1;
        end else cnt_o <= cnt_o - 1'b1;
        PH_HOLD: if (cnt_o == '0) begin
          phase_o <= PH_IDLE;
          done_o  <= 1'b1;
        end else cnt_o <= cnt_o - 1'b1;
        default: phase_o <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amem_bus_drive.sv
module amem_bus_drive
  import amem_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  phase_e        phase_i,
  input  logic [TW-1:0] cnt_i,
  input  logic [TW-1:0] data_setup_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o,
  output logic          cs_no,
  output logic          oe_no,
  output logic          we_no,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic wr_q;
  logic in_data, last_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      addr_o <= '0;
      dq_o   <= '0;
    end else if (start_i) begin
      wr_q   <= write_i;
      addr_o <= addr_i;
      dq_o   <= wdata_i;
    end
  end

  assign in_data   = (phase_i == PH_DATA);
  assign last_data = in_data && (cnt_i == '0);

  // sample on the final data cycle, before output enable rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (last_data && !wr_q) rdata_o <= dq_i;
  end

  assign cs_no   = !((phase_i == PH_ADDR) || in_data);
  assign oe_no   = !(in_data && !wr_q);
  // strobe spans data phase minus its last cycle, never shorter than one
  assign we_no   = !(in_data && wr_q && ((cnt_i != '0) || (data_setup_i == ONE)));
  assign dq_oe_o = wr_q && (in_data || (phase_i == PH_HOLD));
endmodule

// File: rtl/amem_bus_master.sv
module amem_bus_master
  import amem_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_write_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  input  logic [TW-1:0] tim_addr_setup_i,
  input  logic [TW-1:0] tim_data_setup_i,
  input  logic [TW-1:0] tim_addr_hold_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_cs_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  phase_e        phase;
  logic [TW-1:0] cnt;
  logic [TW-1:0] as_now, ds_q, ah_q;
  logic          start;

  assign cmd_ready_o = (phase == PH_IDLE);
  assign start       = cmd_valid_i && cmd_ready_o;

  amem_timing_cfg #(.TW(TW)) i_cfg (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .load_i           (start),
    .addr_setup_i     (tim_addr_setup_i),
    .data_setup_i     (tim_data_setup_i),
    .addr_hold_i      (tim_addr_hold_i),
    .addr_setup_now_o (as_now),
    .data_setup_o     (ds_q),
    .addr_hold_o      (ah_q)
  );

  amem_phase_seq #(.TW(TW)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .addr_setup_i (as_now),
    .data_setup_i (ds_q),
    .addr_hold_i  (ah_q),
    .phase_o      (phase),
    .cnt_o        (cnt),
    .done_o       (rsp_valid_o)
  );

  amem_bus_drive #(.AW(AW), .DW(DW), .TW(TW)) i_drv (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .write_i      (cmd_write_i),
    .addr_i       (cmd_addr_i),
    .wdata_i      (cmd_wdata_i),
    .phase_i      (phase),
    .cnt_i        (cnt),
    .data_setup_i (ds_q),
    .dq_i         (mem_dq_i),
    .rdata_o      (rsp_rdata_o),
    .cs_no        (mem_cs_no),
    .oe_no        (mem_oe_no),
    .we_no        (mem_we_no),
    .addr_o       (mem_addr_o),
    .dq_o         (mem_dq_o),
    .dq_oe_o      (mem_dq_oe_o)
  );
endmodule

// File: rtl/amem_bus_master_chk.sv
module amem_bus_master_chk #(
  parameter int AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic          cmd_ready_o,
  input logic          rsp_valid_o,
  input logic          mem_cs_no,
  input logic          mem_oe_no,
  input logic          mem_we_no,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_dq_oe_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (mem_cs_no && mem_oe_no && mem_we_no && !mem_dq_oe_o));

  p_addr_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));

  p_oe_in_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_cs_no);

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_we_drives_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_dq_oe_o && !mem_cs_no));

  p_busy_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  p_no_drive_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);
endmodule

bind amem_bus_master amem_bus_master_chk #(.AW(AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .mem_cs_no   (mem_cs_no),
  .mem_oe_no   (mem_oe_no),
  .mem_we_no   (mem_we_no),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/test_amem_bus_master.sv
`timescale 1ns/1ps
module test_amem_bus_master;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int TW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_ready_o;
  logic          cmd_write_i = 1'b0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [DW-1:0] cmd_wdata_i = '0;
  logic [TW-1:0] tim_addr_setup_i = 8'd1;
  logic [TW-1:0] tim_data_setup_i = 8'd1;
  logic [TW-1:0] tim_addr_hold_i = 8'd1;
  logic          rsp_valid_o;
  logic [DW-1:0] rsp_rdata_o;
  logic          mem_cs_no, mem_oe_no, mem_we_no;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_dq_o;
  logic          mem_dq_oe_o;
  logic [DW-1:0] mem_dq_i = 16'h0BAD;

  always #5 clk_i = ~clk_i;

  amem_bus_master #(.AW(AW), .DW(DW), .TW(TW)) i_amem_bus_master (.*);

  typedef struct {
    bit            wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    int            a, d, h;
  } item_t;

  item_t         sb_q[$];
  logic [DW-1:0] exp_mem[16];
  logic [DW-1:0] bus_mem[16];
  int            n_chk = 0, n_err = 0;
  bit            done_flag = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  // driver: pushes the expected outcome, then presents the command
  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d,
                       int as, int ds, int ah, bit stray);
    item_t it;
    it.wr = wr; it.addr = a; it.wdata = d;
    it.a = eff(as); it.d = eff(ds); it.h = eff(ah);
    it.rdata = '0;
    if (wr) exp_mem[a[3:0]] = d;
    else it.rdata = exp_mem[a[3:0]] + DW'(it.d - 1);
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_write_i = wr; cmd_addr_i = a; cmd_wdata_i = d;
    tim_addr_setup_i = TW'(as); tim_data_setup_i = TW'(ds); tim_addr_hold_i = TW'(ah);
    cmd_valid_i = 1'b1;
    sb_q.push_back(it);
    @(posedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    if (stray) begin
      // R8 stray command while busy; R9 timing changed mid-access
      cmd_valid_i = 1'b1; cmd_write_i = !wr; cmd_addr_i = 20'hFFFFF;
      tim_addr_setup_i = 8'd15; tim_data_setup_i = 8'd15; tim_addr_hold_i = 8'd15;
      @(negedge clk_i);
      cmd_valid_i = 1'b0;
    end
  endtask

  // memory model: a different word each output-enable cycle
  int oe_k = 0;
  always @(negedge clk_i) begin
    if (!mem_oe_no) begin
      mem_dq_i <= bus_mem[mem_addr_o[3:0]] + DW'(oe_k);
      oe_k <= oe_k + 1;
    end else begin
      mem_dq_i <= 16'h0BAD;
      oe_k <= 0;
    end
    if (!mem_we_no && mem_dq_oe_o) bus_mem[mem_addr_o[3:0]] <= mem_dq_o;
  end

  // monitor: measures each access and compares against the scoreboard
  int  cs_cnt = 0, oe_cnt = 0, we_cnt = 0, lead_cnt = 0, hold_cnt = 0, dqoe_cnt = 0;
  bit  strobe_seen = 0, addr_bad = 0, we_dq_bad = 0, prev_valid = 0, mon_on = 0;
  logic [DW-1:0] last_wd = '0;

  always @(negedge clk_i) begin
    if (mon_on) begin
      if (!mem_cs_no) cs_cnt++;
      if (!mem_oe_no) oe_cnt++;
      if (!mem_we_no) begin
        we_cnt++;
        last_wd = mem_dq_o;
        if (!mem_dq_oe_o) we_dq_bad = 1;
      end
      if (!mem_cs_no && mem_oe_no && mem_we_no && !strobe_seen) lead_cnt++;
      if (!mem_oe_no || !mem_we_no) strobe_seen = 1;
      if (!cmd_ready_o && mem_cs_no) hold_cnt++;
      if (mem_dq_oe_o) dqoe_cnt++;
      if (cmd_ready_o && !(mem_cs_no && mem_oe_no && mem_we_no && !mem_dq_oe_o))
        chk(0, "R1", "idle strobes", 0, 1);
      if (!mem_oe_no && !mem_we_no) chk(0, "R10", "oe/we overlap", 1, 0);
      if ((!cmd_ready_o || !mem_cs_no) && sb_q.size() > 0 && mem_addr_o != sb_q[0].addr)
        addr_bad = 1;
      if (rsp_valid_o) begin
        chk(!prev_valid, "R4", "done width", 2, 1);
        if (sb_q.size() == 0) chk(0, "R8", "unmatched completion", 1, 0);
        else begin
          item_t it;
          it = sb_q.pop_front();
          chk(cs_cnt == it.a + it.d, "R2", "cs low cycles", cs_cnt, it.a + it.d);
          chk(lead_cnt == it.a, "R2", "address setup", lead_cnt, it.a);
          chk(!addr_bad, "R2", "address held", 1, 0);
          chk(hold_cnt == it.h, "R6", "hold cycles", hold_cnt, it.h);
          if (it.wr) begin
            chk(oe_cnt == 0, "R3", "oe in write", oe_cnt, 0);
            chk(we_cnt == ((it.d > 1) ? it.d - 1 : 1), "R5", "we low cycles",
                we_cnt, (it.d > 1) ? it.d - 1 : 1);
            chk(last_wd == it.wdata, "R5", "write data", last_wd, it.wdata);
            chk(!we_dq_bad, "R5", "drive during we", 0, 1);
            chk(dqoe_cnt == it.d + it.h, "R5", "drive cycles", dqoe_cnt, it.d + it.h);
          end else begin
            chk(oe_cnt == it.d, "R3", "oe low cycles", oe_cnt, it.d);
            chk(we_cnt == 0, "R3", "we in read", we_cnt, 0);
            chk(dqoe_cnt == 0, "R10", "drive in read", dqoe_cnt, 0);
            chk(rsp_rdata_o == it.rdata, "R4", "read data", rsp_rdata_o, it.rdata);
          end
        end
        cs_cnt = 0; oe_cnt = 0; we_cnt = 0; lead_cnt = 0; hold_cnt = 0; dqoe_cnt = 0;
        strobe_seen = 0; addr_bad = 0; we_dq_bad = 0;
      end
      prev_valid = rsp_valid_o;
    end
  end

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done_flag) begin
      done_flag = 1;
      chk(0, "WDOG", "watchdog expired", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      exp_mem[i] = 16'h1000 + DW'(i * 16'h0111);
      bus_mem[i] = exp_mem[i];
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(cmd_ready_o && mem_cs_no && mem_oe_no && mem_we_no && !mem_dq_oe_o && !rsp_valid_o,
        "R1", "reset state", 0, 1);
    mon_on = 1;
    issue(1, 20'h00003, 16'hA55A, 5, 4, 1, 0);   // R5
    issue(0, 20'h00003, 16'h0000, 5, 4, 1, 0);   // R3 R4
    issue(1, 20'h10007, 16'h1234, 9, 8, 1, 0);
    issue(0, 20'h10007, 16'h0000, 9, 8, 1, 0);
    issue(0, 20'h00005, 16'h0000, 0, 0, 0, 0);   // R7 all zero
    issue(1, 20'h00006, 16'hBEEF, 0, 0, 0, 0);   // R7 single-cycle strobe
    issue(0, 20'h00006, 16'h0000, 1, 2, 3, 0);   // R6
    issue(1, 20'h2000A, 16'h5A5A, 2, 2, 2, 1);   // R8 R9
    issue(0, 20'h2000A, 16'h0000, 3, 5, 1, 1);   // R8 R9
    issue(1, 20'h0000B, 16'hC3C3, 1, 1, 1, 0);
    issue(0, 20'h0000B, 16'h0000, 2, 1, 2, 0);
    issue(0, 20'h0000F, 16'h0000, 4, 3, 4, 0);
    for (int w = 0; w < 200 && sb_q.size() > 0; w++) @(negedge clk_i);
    chk(sb_q.size() == 0, "R4", "all completions seen", sb_q.size(), 0);
    repeat (10) @(negedge clk_i);
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule